// File: doc/BRIEF.md
# Table Pointer and Flash Write Buffer

This block is the program-memory table access path of a small microcontroller core. It keeps a 22-bit byte pointer, split into three byte-wide registers, and an 8-bit data latch. A table read moves one program-memory byte into the latch. A table write moves the latch into a 16-byte holding buffer. Each table operation carries a pointer-update mode, so that software can walk through memory in either direction without separate address arithmetic.

A program strobe sends the whole holding buffer to memory as one request. The request address is the pointer aligned down to 16 bytes. An erase strobe sends a request whose address is the pointer aligned down to 64 bytes. A single request register stays valid until memory acknowledges it, and the block counts as busy for that whole time. Pointer bit 21 selects a separate space for identification and configuration data. Stepping the pointer never changes that bit.

Top module: `tbl_access_unit`

## Requirements
- R1: After reset the pointer and the latch read 0, every holding byte is 0xFF, and `busy_o`, `req_valid_o` and `op_done_o` are low.
- R2: A register-port write with `reg_sel_i` = 0, 1 or 2 loads pointer bits 7:0, 15:8 or 21:16 respectively (bits 5:0 of the data for the upper byte). With `reg_sel_i` = 3 it loads the latch. `ptr_o` always shows the full pointer.
- R3: A read operation (`op_write_i` = 0) drives the access address on `mem_raddr_o` with `mem_ren_o` high in the same cycle. The latch takes `mem_rdata_i` at the second following edge, and `op_done_o` is high for exactly the cycle after that edge.
- R4: `op_mode_i` selects the pointer update: 0 leaves the pointer unchanged, 1 increments after the access, 2 decrements after the access, and 3 increments before the access, so the access uses pointer+1 and the pointer ends at pointer+1.
- R5: Increment and decrement act on bits 20:0 only and wrap within them (0x1FFFFF+1 gives 0x000000). Bit 21 keeps its value.
- R6: A write operation (`op_write_i` = 1) copies the latch into the holding byte indexed by bits 3:0 of the access address.
- R7: A program strobe (`commit_prog_i`) while not busy raises `req_valid_o` at the next edge. The request carries `req_erase_o` = 0, `req_addr_o` = pointer with bits 3:0 cleared, and holding byte i in `req_data_o[8i+7:8i]`. The holding buffer then returns to all 0xFF.
- R8: An erase strobe (`commit_erase_i`) while not busy, with no program strobe in the same cycle, raises a request with `req_erase_o` = 1, `req_addr_o` = pointer with bits 5:0 cleared, and `req_data_o` all ones. The holding buffer is left intact.
- R9: `busy_o` is high from an accepted strobe until the edge at which `req_ack_i` is sampled high. While busy, write operations change neither the pointer nor the buffer, and new strobes are ignored.
- R10: A register-port write in the same cycle as `op_valid_i` is discarded, and the table operation proceeds.
- R11: While `req_valid_o` is high and `req_ack_i` is low, the request outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register-port write enable |
| reg_sel_i | input | 2 | 0 pointer low, 1 pointer high, 2 pointer upper, 3 latch |
| reg_wdata_i | input | 8 | Register-port write data |
| ptr_o | output | 22 | Current pointer |
| latch_o | output | 8 | Current table latch |
| op_valid_i | input | 1 | Table operation request |
| op_write_i | input | 1 | 1 = table write, 0 = table read |
| op_mode_i | input | 2 | Pointer-update mode |
| op_done_o | output | 1 | Read completion pulse |
| mem_ren_o | output | 1 | Memory read enable |
| mem_raddr_o | output | 22 | Memory read byte address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after address |
| commit_prog_i | input | 1 | Start a program of the holding buffer |
| commit_erase_i | input | 1 | Start a 64-byte block erase |
| req_valid_o | output | 1 | Memory request pending |
| req_erase_o | output | 1 | Request is an erase |
| req_addr_o | output | 22 | Aligned request address |
| req_data_o | output | 128 | Holding buffer snapshot |
| req_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Request outstanding |

## Verification
The hardest case to reach is the busy window. Stimulus that lands there must prove that it had no effect on state the ports cannot show directly. The bench holds the acknowledge off, issues a write operation and an erase strobe inside that window, and checks that the pointer and the pending request do not change. After the acknowledge it programs the buffer again and expects every byte to read 0xFF, which shows that the blocked write never reached the buffer. The wrap corners of the space bit are covered by reads in every update mode from pointers 0x1FFFFF, 0x200000 and 0x3FFFFF.

// File: rtl/tbl_access_pkg.sv
package tbl_access_pkg;
  typedef enum logic [1:0] {
    UPD_NONE     = 2'd0,
    UPD_POST_INC = 2'd1,
    UPD_POST_DEC = 2'd2,
    UPD_PRE_INC  = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    SEL_PTR_LO  = 2'd0,
    SEL_PTR_MID = 2'd1,
    SEL_PTR_UP  = 2'd2,
    SEL_LATCH   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tbl_ptr.sv
module tbl_ptr
  import tbl_access_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_byte_i,
  input  logic [7:0]       wr_data_i,
  input  logic             upd_en_i,
  input  logic [1:0]       upd_mode_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] acc_addr_o
);
  localparam int LOW_W = PTR_W - 1;

  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec, ptr_d;
  upd_mode_e mode;

  assign mode    = upd_mode_e'(upd_mode_i);
  // space bit is held; only the low field steps and wraps
  assign ptr_inc = {ptr_q[PTR_W-1], ptr_q[LOW_W-1:0] + LOW_W'(1)};
  assign ptr_dec = {ptr_q[PTR_W-1], ptr_q[LOW_W-1:0] - LOW_W'(1)};

  always_comb begin
    ptr_d      = ptr_q;
    acc_addr_o = ptr_q;
    case (mode)
      UPD_POST_INC: ptr_d = ptr_inc;
      UPD_POST_DEC: ptr_d = ptr_dec;
      UPD_PRE_INC: begin
        ptr_d      = ptr_inc;
        acc_addr_o = ptr_inc;
      end
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (upd_en_i) begin
      ptr_q <= ptr_d;
    end else if (wr_en_i) begin
      for (int i = 0; i < PTR_W; i++) begin
        if (wr_byte_i == 2'(i / 8)) ptr_q[i] <= wr_data_i[i % 8];
      end
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tbl_hold_buf.sv
module tbl_hold_buf #(
  parameter int NBYTES = 16,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [7:0]          wr_data_i,
  input  logic                clr_i,
  output logic [NBYTES*8-1:0] data_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 byte_q <= 8'hFF;
      else if (clr_i)                              byte_q <= 8'hFF;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   byte_q <= wr_data_i;
    end
    assign data_o[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/tbl_commit.sv
module tbl_commit #(
  parameter int PTR_W       = 22,
  parameter int HOLD_BYTES  = 16,
  parameter int ERASE_BYTES = 64,
  localparam int HOLD_AW  = $clog2(HOLD_BYTES),
  localparam int ERASE_AW = $clog2(ERASE_BYTES),
  localparam int DATA_W   = HOLD_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              ack_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              clr_o,
  output logic              req_valid_o,
  output logic              req_erase_o,
  output logic [PTR_W-1:0]  req_addr_o,
  output logic [DATA_W-1:0] req_data_o
);
  logic prog_go, erase_go;

  assign prog_go  = prog_i && !req_valid_o;
  assign erase_go = erase_i && !prog_i && !req_valid_o;
  assign clr_o    = prog_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_erase_o <= 1'b0;
      req_addr_o  <= '0;
      req_data_o  <= '0;
    end else if (prog_go) begin
      req_valid_o <= 1'b1;
      req_erase_o <= 1'b0;
      req_addr_o  <= {ptr_i[PTR_W-1:HOLD_AW], HOLD_AW'(0)};
      req_data_o  <= hold_i;
    end else if (erase_go) begin
      req_valid_o <= 1'b1;
      req_erase_o <= 1'b1;
      req_addr_o  <= {ptr_i[PTR_W-1:ERASE_AW], ERASE_AW'(0)};
      req_data_o  <= '1;
    end else if (req_valid_o && ack_i) begin
      req_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit
  import tbl_access_pkg::*;
#(
  parameter int PTR_W       = 22,
  parameter int HOLD_BYTES  = 16,
  parameter int ERASE_BYTES = 64,
  localparam int HOLD_AW = $clog2(HOLD_BYTES),
  localparam int DATA_W  = HOLD_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [7:0]        latch_o,
  input  logic              op_valid_i,
  input  logic              op_write_i,
  input  logic [1:0]        op_mode_i,
  output logic              op_done_o,
  output logic              mem_ren_o,
  output logic [PTR_W-1:0]  mem_raddr_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              commit_prog_i,
  input  logic              commit_erase_i,
  output logic              req_valid_o,
  output logic              req_erase_o,
  output logic [PTR_W-1:0]  req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  input  logic              req_ack_i,
  output logic              busy_o
);
  logic             op_go, rd_go, wr_go, rd_pend_q, done_q;
  logic             reg_ok, ptr_reg_we, clr;
  logic [PTR_W-1:0] acc_addr;
  logic [DATA_W-1:0] hold;
  logic [7:0]       latch_q;

  assign busy_o     = req_valid_o;
  assign op_go      = op_valid_i && !(op_write_i && busy_o);
  assign rd_go      = op_go && !op_write_i;
  assign wr_go      = op_go && op_write_i;
  // table operation wins over the register port
  assign reg_ok     = reg_we_i && !op_valid_i;
  assign ptr_reg_we = reg_ok && (reg_sel_e'(reg_sel_i) != SEL_LATCH);

  tbl_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ptr_reg_we),
    .wr_byte_i  (reg_sel_i),
    .wr_data_i  (reg_wdata_i),
    .upd_en_i   (op_go),
    .upd_mode_i (op_mode_i),
    .ptr_o      (ptr_o),
    .acc_addr_o (acc_addr)
  );

  assign mem_ren_o   = rd_go;
  assign mem_raddr_o = acc_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
      latch_q   <= '0;
    end else begin
      rd_pend_q <= rd_go;
      done_q    <= rd_pend_q;
      if (rd_pend_q)
        latch_q <= mem_rdata_i;
      else if (reg_ok && reg_sel_e'(reg_sel_i) == SEL_LATCH)
        latch_q <= reg_wdata_i;
    end
  end

  assign latch_o   = latch_q;
  assign op_done_o = done_q;

  tbl_hold_buf #(.NBYTES(HOLD_BYTES)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_go),
    .wr_idx_i  (acc_addr[HOLD_AW-1:0]),
    .wr_data_i (latch_q),
    .clr_i     (clr),
    .data_o    (hold)
  );

  tbl_commit #(
    .PTR_W       (PTR_W),
    .HOLD_BYTES  (HOLD_BYTES),
    .ERASE_BYTES (ERASE_BYTES)
  ) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_i      (commit_prog_i),
    .erase_i     (commit_erase_i),
    .ack_i       (req_ack_i),
    .ptr_i       (ptr_o),
    .hold_i      (hold),
    .clr_o       (clr),
    .req_valid_o (req_valid_o),
    .req_erase_o (req_erase_o),
    .req_addr_o  (req_addr_o),
    .req_data_o  (req_data_o)
  );
endmodule

// File: rtl/tbl_access_unit_chk.sv
module tbl_access_unit_chk #(
  parameter int PTR_W  = 22,
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic              op_write_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic              busy_i,
  input logic              rd_pend_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic [7:0]        latch_i,
  input logic              done_i,
  input logic              req_valid_i,
  input logic              req_erase_i,
  input logic [PTR_W-1:0]  req_addr_i,
  input logic [DATA_W-1:0] req_data_i,
  input logic              req_ack_i
);
  a_r3_read_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !op_write_i |=> ##1 done_i);

  a_r5_space_bit_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !(op_write_i && busy_i) |=> ptr_i[PTR_W-1] == $past(ptr_i[PTR_W-1]));

  a_r7_prog_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_erase_i |-> req_addr_i[3:0] == 4'h0);

  a_r8_erase_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_erase_i |-> req_addr_i[5:0] == 6'h0);

  a_r9_busy_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && op_valid_i && op_write_i |=> $stable(ptr_i));

  a_r10_latch_reg_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_write_i && reg_we_i && reg_sel_i == 2'd3 && !rd_pend_i
    |=> $stable(latch_i));

  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ack_i |=> req_valid_i && $stable(req_addr_i)
    && $stable(req_data_i) && $stable(req_erase_i));
endmodule

bind tbl_access_unit tbl_access_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_write_i  (op_write_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .busy_i      (busy_o),
  .rd_pend_i   (rd_pend_q),
  .ptr_i       (ptr_o),
  .latch_i     (latch_o),
  .done_i      (op_done_o),
  .req_valid_i (req_valid_o),
  .req_erase_i (req_erase_o),
  .req_addr_i  (req_addr_o),
  .req_data_i  (req_data_o),
  .req_ack_i   (req_ack_i)
);

// File: tb/tbl_access_unit_tb.sv
module tbl_access_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         reg_we = 0, op_valid = 0, op_write = 0;
  logic [1:0]   reg_sel = 0, op_mode = 0;
  logic [7:0]   reg_wdata = 0, latch, mem_rdata = 0;
  logic [21:0]  ptr, mem_raddr, req_addr;
  logic         done, mem_ren, req_valid, req_erase, busy;
  logic         cprog = 0, cerase = 0, ack = 0;
  logic [127:0] req_data;

  int tests = 0, fails = 0;
  logic [21:0] e_ptr = 0;
  logic [7:0]  e_latch = 0;
  logic [7:0]  e_hold [16];
  logic        e_busy = 0;

  tbl_access_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .ptr_o(ptr), .latch_o(latch),
    .op_valid_i(op_valid), .op_write_i(op_write), .op_mode_i(op_mode),
    .op_done_o(done), .mem_ren_o(mem_ren), .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata), .commit_prog_i(cprog), .commit_erase_i(cerase),
    .req_valid_o(req_valid), .req_erase_o(req_erase), .req_addr_o(req_addr),
    .req_data_o(req_data), .req_ack_i(ack), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [21:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {2'b0, a[21:16]} ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_ren) mem_rdata <= mem_byte(mem_raddr);

  function automatic logic [21:0] step(logic [21:0] p, bit up);
    return up ? {p[21], p[20:0] + 21'd1} : {p[21], p[20:0] - 21'd1};
  endfunction

  function automatic logic [127:0] hold_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = e_hold[i];
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    case (sel)
      2'd0: e_ptr[7:0]   = d;
      2'd1: e_ptr[15:8]  = d;
      2'd2: e_ptr[21:16] = d[5:0];
      default: e_latch   = d;
    endcase
  endtask

  task automatic set_ptr(logic [21:0] p);
    reg_wr(2'd0, p[7:0]); reg_wr(2'd1, p[15:8]); reg_wr(2'd2, {2'b0, p[21:16]});
  endtask

  // table operation with model update; coll_sel >= 0 adds a colliding register write
  task automatic table_op(bit wr, logic [1:0] mode, int coll_sel = -1, logic [7:0] coll_d = 0);
    logic [21:0] acc;
    acc = (mode == 2'd3) ? step(e_ptr, 1) : e_ptr;
    @(negedge clk);
    op_valid = 1; op_write = wr; op_mode = mode;
    if (coll_sel >= 0) begin reg_we = 1; reg_sel = 2'(coll_sel); reg_wdata = coll_d; end
    #1;
    if (!wr) begin
      chk("R3 mem_ren", mem_ren, 1);
      chk("R4 access address", mem_raddr, acc);
    end
    @(negedge clk);
    op_valid = 0; reg_we = 0;
    if (!(wr && e_busy)) begin
      if (wr) e_hold[acc[3:0]] = e_latch;
      case (mode)
        2'd1, 2'd3: e_ptr = step(e_ptr, 1);
        2'd2:       e_ptr = step(e_ptr, 0);
        default: ;
      endcase
    end
    chk("R4/R5 pointer update", ptr, e_ptr);
    if (!wr) begin
      chk("R3 done not early", done, 0);
      @(negedge clk);
      e_latch = mem_byte(acc);
      chk("R3 done pulse", done, 1);
      chk("R3 latch data", latch, e_latch);
      @(negedge clk);
      chk("R3 done one cycle", done, 0);
    end else begin
      chk("R10 latch kept", latch, e_latch);
    end
  endtask

  task automatic commit(bit prog);
    @(negedge clk); cprog = prog; cerase = !prog;
    @(negedge clk); cprog = 0; cerase = 0;
    chk("R7/R8 req_valid", req_valid, 1);
    chk("R9 busy", busy, 1);
    chk("R7/R8 req_erase", req_erase, !prog);
    if (prog) begin
      chk("R7 program address", req_addr, {e_ptr[21:4], 4'h0});
      chk("R7 program data", req_data, hold_vec());
      for (int i = 0; i < 16; i++) e_hold[i] = 8'hFF;
    end else begin
      chk("R8 erase address", req_addr, {e_ptr[21:6], 6'h0});
      chk("R8 erase data", req_data, {128{1'b1}});
    end
    e_busy = 1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    e_busy = 0;
    chk("R9 busy cleared", busy, 0);
    chk("R9 req cleared", req_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [21:0] starts [5];
    logic [21:0] addr_held;
    for (int i = 0; i < 16; i++) e_hold[i] = 8'hFF;
    starts = '{22'h000000, 22'h1FFFFF, 22'h200000, 22'h3FFFFF, 22'h0ABCDE};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 pointer", ptr, 0);
    chk("R1 latch", latch, 0);
    chk("R1 busy", busy, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 done", done, 0);

    // R2
    reg_wr(2'd2, 8'hFA); reg_wr(2'd1, 8'h5C); reg_wr(2'd0, 8'h7E);
    chk("R2 pointer bytes", ptr, 22'h3A5C7E);
    reg_wr(2'd3, 8'h96);
    chk("R2 latch write", latch, 8'h96);
    chk("R2 pointer untouched by latch write", ptr, e_ptr);

    // R3 R4 R5: reads in every mode from wrap corners
    foreach (starts[s]) begin
      for (int m = 0; m < 4; m++) begin
        set_ptr(starts[s]);
        table_op(0, 2'(m));
      end
    end

    // R6 R7: fill the buffer with post-increment writes
    set_ptr(22'h212340);
    for (int i = 0; i < 16; i++) begin
      reg_wr(2'd3, 8'(i * 17 + 3));
      table_op(1, 2'd1);
    end
    commit(1);
    // R9: blocked write and strobe while busy
    addr_held = req_addr;
    reg_wr(2'd3, 8'h77);
    table_op(1, 2'd1);
    @(negedge clk); cerase = 1;
    @(negedge clk); cerase = 0;
    chk("R9 strobe ignored while busy", req_erase, 0);
    chk("R11 request held", req_addr, addr_held);
    do_ack();
    commit(1);  // R7 buffer cleared, blocked write absent
    do_ack();

    // R6 with pre-increment, post-decrement and unchanged modes
    set_ptr(22'h00001F);
    reg_wr(2'd3, 8'hC3); table_op(1, 2'd3);
    reg_wr(2'd3, 8'h5A); table_op(1, 2'd2);
    reg_wr(2'd3, 8'h11); table_op(1, 2'd0);
    commit(1);
    do_ack();

    // R8: erase leaves the buffer intact
    set_ptr(22'h2ABCF5);
    reg_wr(2'd3, 8'h42); table_op(1, 2'd0);
    set_ptr(22'h2ABCFF);
    commit(0);
    do_ack();
    commit(1);
    do_ack();

    // R10: register writes colliding with table operations
    set_ptr(22'h001234);
    reg_wr(2'd3, 8'h3C);
    table_op(1, 2'd0, 3, 8'hEE);
    table_op(0, 2'd1, 0, 8'h00);
    table_op(1, 2'd2, 2, 8'h3F);
    commit(1);
    do_ack();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule